// File: doc/BRIEF.md
# Ray Handoff Mesh Element

This block is one processing element of a 2x2x2 grid that together covers a cubic cell domain (by default 16x16x16 cells, so each element owns an 8x8x8 sub-block). Ray records of 96 bits arrive on any of six neighbour input channels. The element queues them, walks each ray one cell per clock through its own sub-block, and bumps a per-cell visit counter for every cell it processes. A ray that steps out of the sub-block goes to the neighbour on the face it crossed. A ray that steps out of the whole domain is absorbed, so an element on the edge of the grid also acts as the boundary sink for that face.

The element runs by itself from reset with no host control. It clears its counter memory once after reset and then takes rays as they arrive. A visit counter read port lets the surrounding logic, or a bench, collect the per-cell totals. The element's position in the grid is set by parameters.

Top module: `ray_mesh_elem`

## Requirements
- R1: A ray record packs, from the MSB down: x, y and z as 10-bit two's complement global cell coordinates (bits 95:86, 85:76, 75:66), then the x, y and z step codes of 2 bits each (65:64, 63:62, 61:60), then a 60-bit payload (59:0). Step code 01 means +1, 11 means -1, and 00 or 10 mean no motion on that axis.
- R2: While walking, the element moves the ray one cell per clock along a single axis. Axes take turns in the order x, y, z, skipping axes with no motion, and each ray starts its turn order at x.
- R3: Each processed cell adds one to that cell's visit counter. The counter is addressed as {z[2:0], y[2:0], x[2:0]} of the local cell, and the read port returns the count one clock after the address is presented.
- R4: A ray whose step leaves the sub-block while staying inside the domain is sent on output face 2*axis+(step>0): 0=x-, 1=x+, 2=y-, 3=y+, 4=z-, 5=z+. It carries the coordinates of the first cell outside the sub-block, and its step codes and payload are unchanged.
- R5: A ray whose step leaves the domain (coordinate below 0 or above 16*... i.e. beyond SUB*ARR-1) is absorbed. This raises `ray_sunk` for exactly one clock and produces no output.
- R6: A ray with no motion on any axis is counted once in its starting cell and is then absorbed.
- R7: An output ray holds its valid and its data unchanged until the matching ready is high.
- R8: Arriving rays wait in a 4-entry FIFO in arrival order. When the FIFO is full, every input ready is low.
- R9: At most one input is accepted per clock, and the lowest-numbered valid input wins. An input's ready is high only when the FIFO is not full and no lower-numbered input is valid.
- R10: After reset, no output is valid, `ray_sunk` is low, all inputs are ready, and once the clearing sweep ends every visit counter reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 6 | Ray offered on each neighbour input face |
| in_data | input | 576 | Six ray records, face i at bits 96*i+95:96*i |
| in_ready | output | 6 | Ray taken on that face this clock |
| out_valid | output | 6 | Ray offered to the neighbour on that face |
| out_data | output | 96 | Outgoing ray record |
| out_ready | input | 6 | Neighbour on that face accepts the ray |
| ray_sunk | output | 1 | One-clock pulse when a ray is absorbed |
| cnt_addr | input | 9 | Visit counter read address |
| cnt_data | output | 16 | Visit counter value, one clock after address |

## Verification
Single-axis rays exercise the face selection on both the lower and the upper side of the sub-block. A diagonal ray with three moving axes checks the turn order, because a different order would change both the exit face and the cells that get counted. A ray with no motion and a ray aimed off the domain edge exercise the sink path. A stalled output filling the FIFO shows the full condition and the arrival order. Two simultaneous inputs show the arbitration. Random rays entering on random faces are then compared against a reference walk, both for each exit and for all 512 cell totals.

// File: rtl/rme_pkg.sv
package rme_pkg;
  localparam int RAY_W = 96;
  localparam int CRD_W = 10;
  localparam int PAY_W = 60;
  localparam int NFACE = 6;

  typedef struct packed {
    logic [CRD_W-1:0] x;
    logic [CRD_W-1:0] y;
    logic [CRD_W-1:0] z;
    logic [1:0]       dx;
    logic [1:0]       dy;
    logic [1:0]       dz;
    logic [PAY_W-1:0] pay;
  } ray_t;

  // step code to signed coordinate increment
  function automatic logic [CRD_W-1:0] dir_step(input logic [1:0] d);
    case (d)
      2'b01:   return CRD_W'(1);
      2'b11:   return '1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rme_ray_fifo.sv
module rme_ray_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + (AW+1)'(1);
      else if (do_pop && !do_push) cnt <= cnt - (AW+1)'(1);
    end
  end
endmodule

// File: rtl/rme_visit_ram.sv
module rme_visit_ram #(
  parameter int AW    = 9,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [AW-1:0]    inc_addr,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             busy
);
  localparam int DEPTH = 1 << AW;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    clr_addr;
  logic             clearing;

  assign busy = clearing;

  // one-pass clearing sweep after reset keeps the array free of a reset net
  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_addr <= '0;
    end else if (clearing) begin
      clr_addr <= clr_addr + AW'(1);
      if (clr_addr == '1) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clearing)  mem[clr_addr] <= '0;
    else if (inc)  mem[inc_addr] <= mem[inc_addr] + CNT_W'(1);
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rme_walker.sv
module rme_walker
  import rme_pkg::*;
#(
  parameter int SUB   = 8,
  parameter int ARR   = 2,
  parameter int POS_X = 0,
  parameter int POS_Y = 0,
  parameter int POS_Z = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   q_empty,
  input  ray_t                   q_ray,
  output logic                   q_pop,
  input  logic                   mem_busy,
  output logic                   visit_we,
  output logic [3*$clog2(SUB)-1:0] visit_addr,
  output logic [NFACE-1:0]       out_valid,
  output ray_t                   out_ray,
  input  logic [NFACE-1:0]       out_ready,
  output logic                   sunk
);
  localparam int LW  = $clog2(SUB);
  localparam int DOM = SUB * ARR;
  localparam int LO [3] = '{POS_X * SUB, POS_Y * SUB, POS_Z * SUB};

  typedef enum logic [1:0] {W_IDLE, W_WALK, W_HOLD} wstate_t;

  wstate_t          st;
  ray_t             cur, nxt_ray;
  logic [1:0]       ptr, sel;
  logic [CRD_W-1:0] crd [3];
  logic [CRD_W-1:0] stp [3];
  logic [CRD_W-1:0] nxt [3];
  logic [2:0]       mov;
  logic             any_mov, in_sub, in_dom;
  int               moved, lo_sel;

  always_comb begin
    crd[0] = cur.x;  crd[1] = cur.y;  crd[2] = cur.z;
    stp[0] = dir_step(cur.dx);
    stp[1] = dir_step(cur.dy);
    stp[2] = dir_step(cur.dz);
    for (int i = 0; i < 3; i++) mov[i] = (stp[i] != '0);
    any_mov = |mov;
  end

  // turn order: first moving axis at or after ptr, wrapping x, y, z
  always_comb begin
    int  idx;
    logic found;
    sel   = ptr;
    found = 1'b0;
    for (int k = 0; k < 3; k++) begin
      idx = (int'(ptr) + k) % 3;
      if (!found && mov[idx]) begin
        sel   = 2'(idx);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++)
      nxt[i] = crd[i] + ((2'(i) == sel) ? stp[i] : '0);
    moved  = int'($signed(nxt[sel]));
    lo_sel = LO[sel];
    in_sub = (moved >= lo_sel) && (moved <= lo_sel + SUB - 1);
    in_dom = (moved >= 0) && (moved <= DOM - 1);
    nxt_ray   = cur;
    nxt_ray.x = nxt[0];
    nxt_ray.y = nxt[1];
    nxt_ray.z = nxt[2];
  end

  assign q_pop      = (st == W_IDLE) && !q_empty && !mem_busy;
  assign visit_we   = (st == W_WALK);
  assign visit_addr = {crd[2][LW-1:0], crd[1][LW-1:0], crd[0][LW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      cur       <= '0;
      ptr       <= '0;
      out_valid <= '0;
      out_ray   <= '0;
      sunk      <= 1'b0;
    end else begin
      sunk <= 1'b0;
      case (st)
        W_IDLE: if (q_pop) begin
          cur <= q_ray;
          ptr <= '0;
          st  <= W_WALK;
        end
        W_WALK: begin
          if (!any_mov || (!in_sub && !in_dom)) begin
            sunk <= 1'b1;
            st   <= W_IDLE;
          end else if (in_sub) begin
            cur <= nxt_ray;
            ptr <= (sel == 2'd2) ? 2'd0 : sel + 2'd1;
          end else begin
            out_ray   <= nxt_ray;
            out_valid <= NFACE'(1) << {sel, stp[sel] == CRD_W'(1)};
            st        <= W_HOLD;
          end
        end
        W_HOLD: if (|(out_valid & out_ready)) begin
          out_valid <= '0;
          st        <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ray_mesh_elem.sv
module ray_mesh_elem
  import rme_pkg::*;
#(
  parameter int SUB        = 8,
  parameter int ARR        = 2,
  parameter int POS_X      = 0,
  parameter int POS_Y      = 0,
  parameter int POS_Z      = 0,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NFACE-1:0]         in_valid,
  input  logic [NFACE*RAY_W-1:0]   in_data,
  output logic [NFACE-1:0]         in_ready,
  output logic [NFACE-1:0]         out_valid,
  output logic [RAY_W-1:0]         out_data,
  input  logic [NFACE-1:0]         out_ready,
  output logic                     ray_sunk,
  input  logic [3*$clog2(SUB)-1:0] cnt_addr,
  output logic [CNT_W-1:0]         cnt_data
);
  localparam int AW = 3 * $clog2(SUB);

  logic             q_full, q_empty, q_pop, push, mem_busy, visit_we;
  logic [RAY_W-1:0] push_data, q_data;
  logic [AW-1:0]    visit_addr;
  ray_t             out_ray;

  // fixed-priority input pick, lowest face index first
  always_comb begin
    logic seen;
    seen      = 1'b0;
    push      = 1'b0;
    push_data = '0;
    for (int i = 0; i < NFACE; i++) begin
      in_ready[i] = !q_full && !seen;
      if (in_valid[i] && !seen) begin
        push      = !q_full;
        push_data = in_data[i*RAY_W +: RAY_W];
      end
      seen = seen | in_valid[i];
    end
  end

  rme_ray_fifo #(.W(RAY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(push_data), .pop(q_pop),
    .rdata(q_data), .full(q_full), .empty(q_empty)
  );

  rme_walker #(.SUB(SUB), .ARR(ARR), .POS_X(POS_X), .POS_Y(POS_Y), .POS_Z(POS_Z)) u_walk (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_ray(ray_t'(q_data)), .q_pop(q_pop),
    .mem_busy(mem_busy), .visit_we(visit_we), .visit_addr(visit_addr),
    .out_valid(out_valid), .out_ray(out_ray), .out_ready(out_ready), .sunk(ray_sunk)
  );

  rme_visit_ram #(.AW(AW), .CNT_W(CNT_W)) u_visits (
    .clk(clk), .rst(rst), .inc(visit_we), .inc_addr(visit_addr),
    .rd_addr(cnt_addr), .rd_data(cnt_data), .busy(mem_busy)
  );

  assign out_data = out_ray;
endmodule

// File: rtl/rme_checker.sv
module rme_checker
  import rme_pkg::*;
#(
  parameter int SUB   = 8,
  parameter int POS_X = 0,
  parameter int POS_Y = 0,
  parameter int POS_Z = 0
) (
  input logic               clk,
  input logic               rst,
  input logic [NFACE-1:0]   in_valid,
  input logic [NFACE-1:0]   in_ready,
  input logic [NFACE-1:0]   out_valid,
  input logic [RAY_W-1:0]   out_data,
  input logic [NFACE-1:0]   out_ready,
  input logic               ray_sunk
);
  localparam int LO [3] = '{POS_X * SUB, POS_Y * SUB, POS_Z * SUB};

  assert_one_face_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (|out_valid && !(|(out_valid & out_ready))) |=> (out_valid == $past(out_valid)) && $stable(out_data));

  assert_sink_excl_R5: assert property (@(posedge clk) disable iff (rst)
    ray_sunk |-> (out_valid == '0));

  assert_sink_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ray_sunk |=> !ray_sunk);

  assert_single_accept_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(in_valid & in_ready) <= 1);

  for (genvar a = 0; a < 3; a++) begin : g_axis
    assert_exit_low_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid[2*a] |-> out_data[RAY_W-1-CRD_W*a -: CRD_W] == CRD_W'(LO[a] - 1));
    assert_exit_high_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid[2*a+1] |-> out_data[RAY_W-1-CRD_W*a -: CRD_W] == CRD_W'(LO[a] + SUB));
  end
endmodule

bind ray_mesh_elem rme_checker #(.SUB(SUB), .POS_X(POS_X), .POS_Y(POS_Y), .POS_Z(POS_Z)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .ray_sunk(ray_sunk)
);

// File: tb/ray_mesh_elem_tb_top.sv
module ray_mesh_elem_tb_top;
  localparam int SUB = 8, ARR = 2, PX = 1, PY = 0, PZ = 1;
  localparam int LW = 3, NCELL = 512, DOM = SUB * ARR;
  localparam int LOS [3] = '{PX * SUB, PY * SUB, PZ * SUB};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [5:0]   in_valid, in_ready, out_valid, out_ready;
  logic [575:0] in_data;
  logic [95:0]  out_data;
  logic         ray_sunk;
  logic [8:0]   cnt_addr;
  logic [15:0]  cnt_data;

  ray_mesh_elem #(.SUB(SUB), .ARR(ARR), .POS_X(PX), .POS_Y(PY), .POS_Z(PZ),
                  .FIFO_DEPTH(4), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .ray_sunk(ray_sunk), .cnt_addr(cnt_addr), .cnt_data(cnt_data)
  );

  int n_chk = 0, n_bad = 0;
  int exp_cnt [NCELL];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mk(input int x, input int y, input int z,
                                     input logic [1:0] dx, input logic [1:0] dy,
                                     input logic [1:0] dz, input logic [59:0] p);
    logic [9:0] xs, ys, zs;
    xs = x[9:0]; ys = y[9:0]; zs = z[9:0];
    return {xs, ys, zs, dx, dy, dz, p};
  endfunction

  function automatic int dval(input logic [1:0] d);
    if (d == 2'b01) return 1;
    if (d == 2'b11) return -1;
    return 0;
  endfunction

  // reference walk per R1, R2, R4, R5, R6 with visit bookkeeping for R3
  task automatic ref_walk(input logic [95:0] r, output int face, output logic [95:0] er);
    int c [3];
    int d [3];
    int ptr, sel;
    c[0] = int'($signed(r[95:86])); c[1] = int'($signed(r[85:76])); c[2] = int'($signed(r[75:66]));
    d[0] = dval(r[65:64]); d[1] = dval(r[63:62]); d[2] = dval(r[61:60]);
    ptr = 0; face = -1; er = '0;
    for (int g = 0; g < 64; g++) begin
      exp_cnt[((c[2] & (SUB-1)) << (2*LW)) | ((c[1] & (SUB-1)) << LW) | (c[0] & (SUB-1))]++;
      if (d[0] == 0 && d[1] == 0 && d[2] == 0) return;
      sel = -1;
      for (int k = 0; k < 3; k++)
        if (sel < 0 && d[(ptr + k) % 3] != 0) sel = (ptr + k) % 3;
      c[sel] += d[sel];
      ptr = (sel + 1) % 3;
      if (c[sel] < LOS[sel] || c[sel] > LOS[sel] + SUB - 1) begin
        if (c[sel] >= 0 && c[sel] <= DOM - 1) begin
          face = 2 * sel + ((d[sel] > 0) ? 1 : 0);
          er = mk(c[0], c[1], c[2], r[65:64], r[63:62], r[61:60], r[59:0]);
        end
        return;
      end
    end
  endtask

  task automatic send_ray(input int port, input logic [95:0] r);
    in_data[port*96 +: 96] = r;
    in_valid[port] = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      #1;
      if (in_ready[port]) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid[port] = 1'b0;
  endtask

  task automatic get_result(output int face, output logic [95:0] d);
    face = -2; d = '0;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (ray_sunk) begin
        face = -1;
        return;
      end
      if (|out_valid) begin
        for (int i = 0; i < 6; i++) if (out_valid[i]) face = i;
        d = out_data;
        out_ready[face] = 1'b1;
        @(negedge clk);
        out_ready = '0;
        return;
      end
    end
  endtask

  task automatic do_ray(input int port, input logic [95:0] r, input string req);
    int ef, af;
    logic [95:0] er, ad;
    ref_walk(r, ef, er);
    send_ray(port, r);
    get_result(af, ad);
    chk(af == ef, {req, " exit face"}, 96'(af), 96'(ef));
    if (ef >= 0) chk(ad == er, {req, " exit record"}, ad, er);
  endtask

  task automatic read_cnt(input int a, output int v);
    @(negedge clk);
    cnt_addr = 9'(a);
    @(negedge clk);
    v = int'(cnt_data);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, f1, f2;
    logic [95:0] d1, d2, e1, e2, rr;
    logic [95:0] bp [5];
    logic [95:0] bpe [5];
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCELL; i++) exp_cnt[i] = 0;
    in_valid = '0; out_ready = '0; in_data = '0; cnt_addr = '0;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 6'd0, "R10 out_valid", 96'(out_valid), 96'd0);
    chk(ray_sunk == 1'b0, "R10 ray_sunk", 96'(ray_sunk), 96'd0);
    chk(in_ready == 6'h3f, "R10 in_ready", 96'(in_ready), 96'h3f);
    rst = 1'b0;
    repeat (600) @(negedge clk);
    read_cnt(0, v);   chk(v == 0, "R10 counter 0", 96'(v), 96'd0);
    read_cnt(511, v); chk(v == 0, "R10 counter 511", 96'(v), 96'd0);

    // R4 lower x face, R2 single axis
    do_ray(1, mk(8, 3, 10, 2'b11, 2'b00, 2'b00, 60'h123456789), "R4");
    // R5 leaves domain on x+
    do_ray(0, mk(15, 0, 8, 2'b01, 2'b00, 2'b00, 60'h5), "R5");
    // R6 code 10 counts as no motion
    do_ray(3, mk(10, 4, 12, 2'b10, 2'b00, 2'b00, 60'h6), "R6");
    // R2 diagonal turn order, expected exit y+ at (14,8,8)
    rr = mk(12, 6, 9, 2'b01, 2'b01, 2'b11, 60'hABCDEF);
    do_ray(5, rr, "R2");
    // R4 upper z is domain edge, lower z goes to neighbour; z- from 8
    do_ray(2, mk(11, 5, 8, 2'b00, 2'b00, 2'b11, 60'h77), "R4 z-");
    // R3 direct count of a diagonal-path cell (13,7,9): local {1,7,5}
    read_cnt((1 << 6) | (7 << 3) | 5, v);
    chk(v == 1, "R3 diagonal cell", 96'(v), 96'd1);

    // R9 priority between faces 2 and 4
    e1 = mk(8, 1, 9, 2'b11, 2'b00, 2'b00, 60'hA);
    e2 = mk(9, 0, 9, 2'b00, 2'b11, 2'b00, 60'hB);
    ref_walk(e1, f1, d1);
    ref_walk(e2, f2, d2);
    in_data[2*96 +: 96] = e1;
    in_data[4*96 +: 96] = e2;
    in_valid = 6'b010100;
    #1;
    chk(in_ready == 6'b000111, "R9 ready mask", 96'(in_ready), 96'h7);
    @(negedge clk);
    in_valid[2] = 1'b0;
    for (int t = 0; t < 100; t++) begin
      #1;
      if (in_ready[4]) begin @(negedge clk); break; end
      @(negedge clk);
    end
    in_valid = '0;
    get_result(f1, d1);
    chk(f1 == 0 && d1 == mk(7, 1, 9, 2'b11, 2'b00, 2'b00, 60'hA), "R9 first served", d1, mk(7, 1, 9, 2'b11, 2'b00, 2'b00, 60'hA));
    get_result(f2, d2);
    chk(f2 == -1, "R9 second served (R5 sink)", 96'(f2), 96'(-1));

    // R8 and R7: stalled output, FIFO fills
    for (int k = 0; k < 5; k++) begin
      bp[k] = mk(8, k, 8 + k, 2'b11, 2'b00, 2'b00, 60'(100 + k));
      ref_walk(bp[k], f1, bpe[k]);
      send_ray(1, bp[k]);
    end
    in_data[1*96 +: 96] = mk(8, 6, 14, 2'b11, 2'b00, 2'b00, 60'd200);
    in_valid[1] = 1'b1;
    #1;
    chk(in_ready == 6'd0, "R8 full blocks inputs", 96'(in_ready), 96'd0);
    @(negedge clk);
    in_valid = '0;
    repeat (5) @(negedge clk);
    chk(out_valid == 6'b000001 && out_data == bpe[0], "R7 held output", out_data, bpe[0]);
    for (int k = 0; k < 5; k++) begin
      get_result(f1, d1);
      chk(f1 == 0 && d1 == bpe[k], "R8 arrival order", d1, bpe[k]);
    end
    do_ray(1, mk(8, 6, 14, 2'b11, 2'b00, 2'b00, 60'd200), "R8 after drain");

    // random rays, R1 R2 R4 R5 R6
    for (int n = 0; n < 40; n++) begin
      int port;
      logic [59:0] p;
      port = int'($urandom % 6);
      p = {$urandom, $urandom};
      rr = mk(LOS[0] + int'($urandom % SUB), LOS[1] + int'($urandom % SUB), LOS[2] + int'($urandom % SUB),
              2'($urandom), 2'($urandom), 2'($urandom), p);
      do_ray(port, rr, "R1 random");
    end

    // R3 all per-cell totals
    for (int a = 0; a < NCELL; a++) begin
      read_cnt(a, v);
      chk(v == exp_cnt[a], "R3 cell total", 96'(v), 96'(exp_cnt[a]));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule